// File: doc/BRIEF.md
# ADC Result Register Bank

This block sits between an analog-to-digital converter front end and a host. The front end hands over each finished 10-bit conversion result with a one-cycle valid strobe and the channel number it belongs to. The block stores the result in one of four result slots. Each slot appears to the host as a pair of read-only byte registers, one high and one low. The host reads them over a small byte-wide read port.

The mode input selects the slot. In per-channel mode, channel n always lands in slot n. In fixed-channel repeat mode, successive results fill slots 0, 1, 2 and 3 in turn and then wrap back to 0. A restart pulse sends that rotation back to slot 0; the surrounding logic raises it when the mode is rewritten or a conversion sequence is started again.

Each slot has a "new data" flag, which the host sees as bit 0 of its low byte. There is also a global end-of-conversion flag. A store sets both flags. A host read of a slot clears that slot's flag and the end-of-conversion flag.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every slot holds zero, every slot flag is 0, `eoc` is 0, `rd_data` is 0 and the repeat rotation points at slot 0.
- R2: When `repeat_mode` is 0, a result strobed with `res_chan` = n is written into slot n.
- R3: When `repeat_mode` is 1, each strobed result goes to the slot named by a rotation pointer, and the pointer then advances 0→1→2→3→0. `res_chan` is ignored in this mode.
- R4: A `restart` pulse sets the rotation pointer to slot 0 for the next store. If a store happens in the same cycle as the pulse, that store still uses the old pointer value.
- R5: `rd_addr[2:1]` selects the slot and `rd_addr[0]` selects the byte (1 = high byte, 0 = low byte). The high byte holds result bits [9:2]. The low byte holds result bits [1:0] in its bits [7:6], zeros in its bits [5:1], and the slot flag in bit 0.
- R6: A store into a slot sets that slot's flag to 1.
- R7: A read strobe to either byte of a slot clears that slot's flag, and the flags of the other slots keep their values.
- R8: A store sets `eoc` to 1. A read strobe in a cycle with no store clears `eoc` to 0.
- R9: When a store and a read happen in the same cycle, the store wins. `eoc` stays 1, and the stored slot's flag stays 1 even if that slot is the one being read.
- R10: `rd_data` is registered. It shows the addressed byte one cycle after the read strobe, as that byte was before that cycle's store. It holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| repeat_mode | input | 1 | 1 = fixed-channel repeat (rotating slots), 0 = per-channel slots |
| restart | input | 1 | Pulse that returns the rotation pointer to slot 0 |
| res_valid | input | 1 | One-cycle strobe for a finished result |
| res_data | input | 10 | Conversion result |
| res_chan | input | 2 | Channel of the result |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Byte register address |
| rd_data | output | 8 | Registered read data |
| eoc | output | 1 | Global end-of-conversion flag |

## Verification
The bench aims at the cycles where a store and a read meet. It covers a read of the same slot that is being written and a read of a different slot during a store. If the priority were wrong, a flag or `eoc` would drop right after a fresh result arrived. It also runs repeat mode through more than four stores and places a restart next to a store. A pointer that failed to wrap, or that restarted one store too early, would put a result in the wrong slot. The low-byte packing and the pre-store timing of read data are checked on every random read against a model.

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int DATA_W = 10,
  parameter int SLOTS  = 4,
  localparam int SEL_W  = $clog2(SLOTS),
  localparam int ADDR_W = SEL_W + 1,
  localparam int LO_W   = DATA_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              repeat_mode,
  input  logic              restart,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [SEL_W-1:0]  res_chan,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              eoc
);

  logic [7:0]       hi_q [SLOTS];
  logic [LO_W-1:0]  lo_q [SLOTS];
  logic [SLOTS-1:0] flag_q;
  logic [SEL_W-1:0] ptr_q;

  logic [SEL_W-1:0] wr_slot;
  logic [SEL_W-1:0] rd_slot;
  logic [7:0]       rd_mux;

  assign wr_slot = repeat_mode ? ptr_q : res_chan;
  assign rd_slot = rd_addr[ADDR_W-1:1];
  assign rd_mux  = rd_addr[0] ? hi_q[rd_slot]
                              : {lo_q[rd_slot], {(7-LO_W){1'b0}}, flag_q[rd_slot]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end
      flag_q  <= '0;
      ptr_q   <= '0;
      eoc     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (rd_en) begin
        rd_data         <= rd_mux;
        flag_q[rd_slot] <= 1'b0;
        eoc             <= 1'b0;
      end
      if (res_valid) begin
        hi_q[wr_slot]   <= res_data[DATA_W-1:LO_W];
        lo_q[wr_slot]   <= res_data[LO_W-1:0];
        flag_q[wr_slot] <= 1'b1;
        eoc             <= 1'b1;
      end
      if (restart)
        ptr_q <= '0;
      else if (res_valid && repeat_mode)
        ptr_q <= ptr_q + 1'b1;
    end
  end

endmodule

module adc_result_bank_chk #(
  parameter int SLOTS  = 4,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 3,
  parameter int LO_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              repeat_mode,
  input logic              restart,
  input logic              res_valid,
  input logic [SEL_W-1:0]  res_chan,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              eoc,
  input logic [SLOTS-1:0]  flag_q,
  input logic [SEL_W-1:0]  ptr_q
);

  // R8
  eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> eoc);

  // R8
  eoc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !res_valid |=> !eoc);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !repeat_mode |=> flag_q[$past(res_chan)]);

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !res_valid |=> !flag_q[$past(rd_addr[ADDR_W-1:1])]);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && repeat_mode && !restart |=> ptr_q == SEL_W'($past(ptr_q) + 1'b1));

  // R4
  ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ptr_q == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_addr[0] |=> rd_data[7-LO_W:1] == '0);

endmodule

bind adc_result_bank adc_result_bank_chk #(
  .SLOTS(SLOTS), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .LO_W(LO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .repeat_mode(repeat_mode), .restart(restart),
  .res_valid(res_valid), .res_chan(res_chan), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .eoc(eoc), .flag_q(flag_q), .ptr_q(ptr_q)
);

// File: tb/adc_result_bank_tb.sv
`timescale 1ns/1ps
module adc_result_bank_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       repeat_mode = 1'b0, restart = 1'b0, res_valid = 1'b0, rd_en = 1'b0;
  logic [9:0] res_data = '0;
  logic [1:0] res_chan = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       eoc;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] m_hi [4];
  logic [1:0] m_lo [4];
  logic [3:0] m_flag;
  logic [1:0] m_ptr;
  logic       m_eoc;
  logic [7:0] m_rd;

  always #2.5 clk = ~clk;

  adc_result_bank u_dut (
    .clk(clk), .rst_n(rst_n), .repeat_mode(repeat_mode), .restart(restart),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .eoc(eoc)
  );

  function automatic logic [7:0] byte_of(input logic [2:0] a);
    return a[0] ? m_hi[a[2:1]] : {m_lo[a[2:1]], 5'b0, m_flag[a[2:1]]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
    m_flag = '0; m_ptr = '0; m_eoc = 0; m_rd = '0;
  endtask

  task automatic step(input bit v, input logic [1:0] ch, input logic [9:0] d,
                      input bit rm, input bit rs, input bit re, input logic [2:0] ra,
                      input string tag);
    logic [1:0] slot;
    @(negedge clk);
    res_valid = v; res_chan = ch; res_data = d; repeat_mode = rm;
    restart = rs; rd_en = re; rd_addr = ra;
    if (re) begin
      m_rd = byte_of(ra);
      m_flag[ra[2:1]] = 1'b0;
      m_eoc = 1'b0;
    end
    if (v) begin
      slot = rm ? m_ptr : ch;
      m_hi[slot] = d[9:2];
      m_lo[slot] = d[1:0];
      m_flag[slot] = 1'b1;
      m_eoc = 1'b1;
    end
    if (rs) m_ptr = '0;
    else if (v && rm) m_ptr = m_ptr + 1'b1;
    @(posedge clk);
    #1;
    check({tag, " R10 rd_data"}, rd_data, m_rd);
    check({tag, " R8 eoc"}, {7'b0, eoc}, {7'b0, m_eoc});
    res_valid = 0; restart = 0; rd_en = 0;
  endtask

  task automatic read_all(input bit rm, input string tag);
    for (int a = 0; a < 8; a++) step(0, 0, 0, rm, 0, 1, 3'(a), tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0a1c);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0;
    check("R1 eoc after reset", {7'b0, eoc}, 8'h00);
    check("R1 rd_data after reset", rd_data, 8'h00);
    read_all(0, "R1");

    step(1, 2, 10'h2d6, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 3'b101, "R2 R5 hi");
    step(0, 0, 0, 0, 0, 1, 3'b100, "R5 R6 R7 lo");
    step(0, 0, 0, 0, 0, 1, 3'b100, "R7 cleared");

    step(1, 3, 10'h3ff, 0, 0, 1, 3'b111, "R9 same slot");
    step(0, 0, 0, 0, 0, 1, 3'b110, "R9 flag kept");
    step(1, 0, 10'h155, 0, 0, 1, 3'b011, "R9 other slot");
    read_all(0, "R7");

    step(0, 0, 0, 1, 1, 0, 0, "R4");
    for (int k = 0; k < 6; k++) step(1, 2'(k), 10'(37 * k + 5), 1, 0, 0, 0, "R3");
    read_all(1, "R3");
    step(1, 1, 10'h0a3, 1, 1, 0, 0, "R4 same-cycle");
    step(1, 3, 10'h1c4, 1, 0, 0, 0, "R4 after");
    read_all(1, "R4");

    for (int k = 0; k < 3000; k++) begin
      step($urandom_range(0, 2) == 0, 2'($urandom), 10'($urandom),
           (k / 500) % 2 == 1, $urandom_range(0, 30) == 0,
           $urandom_range(0, 1) == 0, 3'($urandom), "R2 R3 R7 random");
    end
    read_all(0, "R5 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule